// File: doc/BRIEF.md
# Command Issue and Response Capture Unit

This register-level unit lets software launch one card command at a time and collect the card's reply. Software loads a 32-bit argument and a 13-bit control word; writing the control word with its start bit set hands the command index, the argument and the response options to a card-side request/acknowledge handshake. The card side then either streams response bytes, marking the final one, or reports a timeout.

Incoming bytes are packed into four 32-bit response words, most significant byte first. A command status register records the index of the last accepted command and carries sticky event bits that software clears by writing ones. Three events (command accepted, response complete, timeout) each produce a one-cycle interrupt pulse when enabled in a mask register. A one-cycle completion pulse lets a following data-transfer unit start once the command phase is over.

Register map (word address on `wr_addr`/`rd_addr`): 0 argument, 1 control, 2 status, 3 interrupt mask, 4 to 7 response words 0 to 3.

Top module: `sdcmd_issue`

## Requirements
- R1: After a synchronous reset every register reads 0, and `cmd_valid`, `irq` and `cmd_done` are low.
- R2: A write to control (address 1) with bit 8 set raises `cmd_valid` on the next cycle, with `cmd_index` equal to control bits 5:0 and `cmd_arg` equal to the argument register. Both are held until `cmd_ready` is seen high.
- R3: When the handshake completes, status bits 5:0 take the command index, status bit 11 (sent) is set, bit 12 is cleared, and bits 9 and 10 keep their values. Status bit 8 reads 1 while a command is outstanding.
- R4: With control bit 9 (await response) clear, `cmd_done` pulses in the cycle after the handshake and no response is captured.
- R5: Response byte number i (from 0) is stored in word i/4 at bits [(3 - i%4)*8 + 7 : (3 - i%4)*8]. A six-byte short response fills word 0 and the upper half of word 1.
- R6: With control bit 10 (long response) set, a 17-byte stream fills all four words with bytes 0 to 15, and byte 16 is dropped.
- R7: A byte flagged `resp_last` sets status bit 9. A `resp_timeout` pulse sets status bit 10. Either one ends the command and pulses `cmd_done` on the next cycle.
- R8: All four response words are cleared when a new command is accepted.
- R9: A write to status (address 2) clears each of bits 9 to 12 that is written as 1. No other status bit is affected.
- R10: `irq` pulses for one cycle on an event only if its mask bit is set: mask bit 0 for sent, bit 1 for response complete, bit 2 for timeout.
- R11: While a command is outstanding, writes to the control and argument registers are ignored: no second command starts and both registers read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| cmd_valid | output | 1 | Command request to the card side |
| cmd_ready | input | 1 | Card side accepts the command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_wait_rsp | output | 1 | A response is expected |
| cmd_long_rsp | output | 1 | A long response is expected |
| resp_valid | input | 1 | Response byte valid |
| resp_byte | input | 8 | Response byte |
| resp_last | input | 1 | Final response byte |
| resp_timeout | input | 1 | The card did not answer |
| irq | output | 1 | Masked event interrupt pulse |
| cmd_done | output | 1 | Command phase finished pulse |

## Verification
The bound assertions check on every cycle that the request holds steady until it is acknowledged, that an accepted command records its index and sent bit and clears the response words, that the completion pulse never overlaps an outstanding command, that a busy-time control write leaves the control register unchanged, and that an interrupt only follows an enabled mask. Only the directed scenarios can show the exact byte placement of short and long responses, the dropping of the seventeenth byte, the write-one-to-clear behaviour of the sticky bits, and the per-event pulse counts for different mask settings.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam logic [2:0] A_ARG  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam int unsigned RSP_BASE = 4;

  localparam int unsigned CTL_START = 8;
  localparam int unsigned CTL_WAIT  = 9;
  localparam int unsigned CTL_LONG  = 10;

  localparam int unsigned ST_BUSY = 8;
  localparam int unsigned ST_RSP  = 9;
  localparam int unsigned ST_TOUT = 10;
  localparam int unsigned ST_SENT = 11;
  localparam int unsigned ST_CRC  = 12;

  localparam int unsigned MSK_SENT = 0;
  localparam int unsigned MSK_RSP  = 1;
  localparam int unsigned MSK_TOUT = 2;
  localparam int unsigned MSK_W    = 3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RESP} cmd_state_t;
endpackage

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wait_rsp,
  input  logic cmd_ready,
  input  logic resp_valid,
  input  logic resp_last,
  input  logic resp_timeout,
  output logic cmd_valid,
  output logic busy,
  output logic ev_accept,
  output logic ev_byte,
  output logic ev_rsp_end,
  output logic ev_tout
);
  cmd_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE:  if (start) state_q <= S_ISSUE;
        S_ISSUE: if (cmd_ready) state_q <= wait_rsp ? S_RESP : S_IDLE;
        S_RESP:  if (resp_timeout || (resp_valid && resp_last)) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_valid  = (state_q == S_ISSUE);
  assign busy       = (state_q != S_IDLE);
  assign ev_accept  = cmd_valid && cmd_ready;
  assign ev_tout    = (state_q == S_RESP) && resp_timeout;
  assign ev_byte    = (state_q == S_RESP) && resp_valid && !resp_timeout;
  assign ev_rsp_end = ev_byte && resp_last;
endmodule

// File: rtl/sdcmd_resp_pack.sv
module sdcmd_resp_pack #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    we,
  input  logic [7:0]              din,
  output logic [WORDS*WORD_W-1:0] words
);
  localparam int unsigned LANES = WORD_W / 8;
  localparam int unsigned TOTAL = WORDS * LANES;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (we && cnt_q != CNT_W'(TOTAL)) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int unsigned POS = w * LANES + (LANES - 1 - l);
      logic [7:0] b_q;
      always_ff @(posedge clk) begin
        if (rst || clr) b_q <= '0;
        else if (we && cnt_q == CNT_W'(POS)) b_q <= din;
      end
      assign words[w*WORD_W + l*8 +: 8] = b_q;
    end
  end
endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
  import sdcmd_pkg::*;
#(
  parameter int unsigned ARG_W      = 32,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned CTRL_W     = 13,
  parameter int unsigned RESP_WORDS = 4,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ARG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ARG_W-1:0]  rd_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [IDX_W-1:0]  cmd_index,
  output logic [ARG_W-1:0]  cmd_arg,
  output logic              cmd_wait_rsp,
  output logic              cmd_long_rsp,
  input  logic              resp_valid,
  input  logic [7:0]        resp_byte,
  input  logic              resp_last,
  input  logic              resp_timeout,
  output logic              irq,
  output logic              cmd_done
);
  localparam int unsigned RSP_FLAT = RESP_WORDS * ARG_W;

  logic [ARG_W-1:0]    arg_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [CTRL_W-1:0]   stat_q, stat_d, stat_rd;
  logic [MSK_W-1:0]    mask_q;
  logic [RSP_FLAT-1:0] resp_flat;
  logic                busy, ev_accept, ev_byte, ev_rsp_end, ev_tout;
  logic                wr_ctrl_ok, start;

  assign wr_ctrl_ok = wr_en && (wr_addr == A_CTRL) && !busy;
  assign start      = wr_ctrl_ok && wr_data[CTL_START];

  sdcmd_fsm u_fsm (
    .clk, .rst, .start,
    .wait_rsp(ctrl_q[CTL_WAIT]),
    .cmd_ready, .resp_valid, .resp_last, .resp_timeout,
    .cmd_valid, .busy, .ev_accept, .ev_byte, .ev_rsp_end, .ev_tout
  );

  sdcmd_resp_pack #(.WORDS(RESP_WORDS), .WORD_W(ARG_W)) u_pack (
    .clk, .rst, .clr(ev_accept), .we(ev_byte), .din(resp_byte), .words(resp_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q  <= '0;
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_ARG && !busy) arg_q <= wr_data;
      if (wr_ctrl_ok) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[MSK_W-1:0];
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (wr_en && wr_addr == A_STAT) begin
      for (int b = ST_RSP; b <= ST_CRC; b++)
        if (wr_data[b]) stat_d[b] = 1'b0;
    end
    if (ev_accept) begin
      stat_d[IDX_W-1:0] = ctrl_q[IDX_W-1:0];
      stat_d[ST_CRC]    = 1'b0;
      stat_d[ST_SENT]   = 1'b1;
    end
    if (ev_rsp_end) stat_d[ST_RSP]  = 1'b1;
    if (ev_tout)    stat_d[ST_TOUT] = 1'b1;
    stat_d[ST_BUSY] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      irq      <= 1'b0;
      cmd_done <= 1'b0;
    end else begin
      stat_q   <= stat_d;
      irq      <= (ev_accept  && mask_q[MSK_SENT]) ||
                  (ev_rsp_end && mask_q[MSK_RSP])  ||
                  (ev_tout    && mask_q[MSK_TOUT]);
      cmd_done <= (ev_accept && !ctrl_q[CTL_WAIT]) || ev_rsp_end || ev_tout;
    end
  end

  always_comb begin
    stat_rd          = stat_q;
    stat_rd[ST_BUSY] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr == A_ARG)       rd_data <= arg_q;
      else if (rd_addr == A_CTRL) rd_data <= ARG_W'(ctrl_q);
      else if (rd_addr == A_STAT) rd_data <= ARG_W'(stat_rd);
      else if (rd_addr == A_MASK) rd_data <= ARG_W'(mask_q);
      else if (int'(rd_addr) >= RSP_BASE && int'(rd_addr) < RSP_BASE + RESP_WORDS)
        rd_data <= resp_flat[(int'(rd_addr) - RSP_BASE) * ARG_W +: ARG_W];
      else rd_data <= '0;
    end
  end

  assign cmd_index    = ctrl_q[IDX_W-1:0];
  assign cmd_arg      = arg_q;
  assign cmd_wait_rsp = ctrl_q[CTL_WAIT];
  assign cmd_long_rsp = ctrl_q[CTL_LONG];
endmodule

// File: rtl/sdcmd_issue_chk.sv
module sdcmd_issue_chk #(
  parameter int unsigned ARG_W    = 32,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned CTRL_W   = 13,
  parameter int unsigned RSP_FLAT = 128,
  parameter int unsigned ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [IDX_W-1:0]  cmd_index,
  input logic [ARG_W-1:0]  cmd_arg,
  input logic              irq,
  input logic              cmd_done,
  input logic              busy,
  input logic              ev_accept,
  input logic [CTRL_W-1:0] stat_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [2:0]        mask_q,
  input logic [RSP_FLAT-1:0] resp_flat
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_arg));

  assert_sent_index_R3: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> stat_q[11] && stat_q[IDX_W-1:0] == $past(cmd_index));

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> !busy);

  assert_resp_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> resp_flat == '0);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mask_q) != 3'b000);

  assert_busy_ctrl_kept_R11: assert property (@(posedge clk) disable iff (rst)
    busy && wr_en && wr_addr == 3'd1 |=> $stable(ctrl_q));
endmodule

bind sdcmd_issue sdcmd_issue_chk #(
  .ARG_W(ARG_W), .IDX_W(IDX_W), .CTRL_W(CTRL_W),
  .RSP_FLAT(RESP_WORDS * ARG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
  .cmd_arg(cmd_arg), .irq(irq), .cmd_done(cmd_done), .busy(busy),
  .ev_accept(ev_accept), .stat_q(stat_q), .ctrl_q(ctrl_q),
  .mask_q(mask_q), .resp_flat(resp_flat)
);

// File: tb/sdcmd_issue_bench.sv
module sdcmd_issue_bench;
  logic        clk = 0, rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        cmd_valid, cmd_ready = 0;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        cmd_wait_rsp, cmd_long_rsp;
  logic        resp_valid = 0, resp_last = 0, resp_timeout = 0;
  logic [7:0]  resp_byte = 0;
  logic        irq, cmd_done;

  int checks = 0, failures = 0, irq_n = 0, done_n = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdcmd_issue u_sdcmd_issue (.*);

  always @(posedge clk) begin
    if (irq) irq_n++;
    if (cmd_done) done_n++;
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic run_cmd(input logic [12:0] ctrl, input logic [31:0] argv,
                         input int nbytes, input int step, input bit tout);
    irq_n = 0; done_n = 0;
    wr(3'd0, argv);
    wr(3'd1, 32'(ctrl));
    chk("R2 cmd_valid raised", 32'(cmd_valid), 1);
    chk("R2 cmd_index", 32'(cmd_index), 32'(ctrl[5:0]));
    chk("R2 cmd_arg", cmd_arg, argv);
    repeat (2) @(negedge clk);
    chk("R2 cmd_valid held", 32'(cmd_valid), 1);
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
    if (tout) begin
      resp_timeout = 1; @(negedge clk); resp_timeout = 0;
    end else begin
      for (int i = 0; i < nbytes; i++) begin
        resp_valid = 1; resp_byte = 8'((i + 1) * step); resp_last = (i == nbytes - 1);
        @(negedge clk);
      end
      resp_valid = 0; resp_last = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 done", 32'(cmd_done), 0);
    rd(3'd2, d); chk("R1 status", d, 0);
    rd(3'd4, d); chk("R1 resp0", d, 0);
  endtask

  task automatic t_short();
    logic [31:0] d;
    wr(3'd3, 32'h7);
    run_cmd(13'h311, 32'hA5A5_5A5A, 6, 8'h11, 0);
    rd(3'd4, d); chk("R5 word0", d, 32'h1122_3344);
    rd(3'd5, d); chk("R5 word1", d, 32'h5566_0000);
    rd(3'd6, d); chk("R5 word2", d, 0);
    rd(3'd2, d); chk("R3 R7 status after short", d, 32'hA11);
    chk("R10 irq sent+rsp", irq_n, 2);
    chk("R7 done count", done_n, 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(3'd2, 32'h200); rd(3'd2, d); chk("R9 clear bit9", d, 32'h811);
    wr(3'd2, 32'h0);   rd(3'd2, d); chk("R9 zero write keeps", d, 32'h811);
    wr(3'd2, 32'h1FFF); rd(3'd2, d); chk("R9 clear all sticky", d, 32'h011);
  endtask

  task automatic t_noresp();
    logic [31:0] d;
    wr(3'd3, 32'h0);
    run_cmd(13'h100, 32'h1, 0, 0, 0);
    rd(3'd2, d); chk("R3 R4 status", d, 32'h800);
    rd(3'd4, d); chk("R8 word0 cleared", d, 0);
    rd(3'd5, d); chk("R8 word1 cleared", d, 0);
    chk("R4 done pulse", done_n, 1);
    chk("R10 masked off", irq_n, 0);
  endtask

  task automatic t_long();
    logic [31:0] d;
    wr(3'd3, 32'h2);
    run_cmd(13'h702, 32'hDEAD_BEEF, 17, 1, 0);
    rd(3'd4, d); chk("R6 word0 (byte16 dropped)", d, 32'h0102_0304);
    rd(3'd5, d); chk("R6 word1", d, 32'h0506_0708);
    rd(3'd6, d); chk("R6 word2", d, 32'h090A_0B0C);
    rd(3'd7, d); chk("R6 word3", d, 32'h0D0E_0F10);
    rd(3'd2, d); chk("R3 sticky sent", d, 32'hA02);
    chk("R10 rsp only", irq_n, 1);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    wr(3'd2, 32'h1E00);
    wr(3'd3, 32'h4);
    run_cmd(13'h305, 32'h55, 0, 0, 1);
    rd(3'd2, d); chk("R7 timeout status", d, 32'hC05);
    rd(3'd4, d); chk("R8 word0 cleared", d, 0);
    chk("R10 timeout irq", irq_n, 1);
    chk("R7 timeout done", done_n, 1);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr(3'd3, 32'h0);
    done_n = 0;
    wr(3'd0, 32'h1234);
    wr(3'd1, 32'h309);
    rd(3'd2, d); chk("R3 busy bit", d, 32'hD05);
    wr(3'd1, 32'h30C);
    wr(3'd0, 32'h9999);
    rd(3'd1, d); chk("R11 ctrl kept", d, 32'h309);
    rd(3'd0, d); chk("R11 arg kept", d, 32'h1234);
    chk("R11 index kept", 32'(cmd_index), 9);
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
    resp_timeout = 1; @(negedge clk); resp_timeout = 0;
    repeat (4) @(negedge clk);
    chk("R11 still idle", 32'(cmd_valid), 0);
    rd(3'd2, d); chk("R11 status index", d, 32'hC09);
    chk("R11 single done", done_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_short();
    t_clear();
    t_noresp();
    t_long();
    t_timeout();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule